// File: doc/BRIEF.md
# Dual-Mode PWM Timer with Offset Outputs

This block is a 16-bit compare timer that drives a set of capture/compare channels. The counter runs from zero up to a programmable period. In edge mode it then restarts at zero, which gives edge-aligned PWM. In center mode it counts back down to zero, which gives center-aligned PWM. Each channel has a primary output and a secondary output. The primary output switches where the counter reaches the channel's compare value. The secondary output switches where the counter reaches that compare value plus a shared offset. This lets the two outputs of a channel have edges that never coincide. The level each channel starts a period with can be chosen per channel, so the waveforms can be inverted.

Any channel can be set to capture instead. A rising edge on its input pin is passed through a synchronizer, and the counter value at that moment is stored. Stored captures leave the block on a valid/ready stream. The stream holds `cap_valid` high while any capture is still unconsumed. It presents the lowest-numbered pending channel, and a handshake retires that channel. Back-pressure does not stall capturing. While a channel waits, a newer capture on it replaces its value, and a capture on a lower-numbered channel takes over the stream. A consumer therefore always takes the latest value, and a capture is never blocked. Software programs the block through a write-only port: an address, a data word and a write strobe.

Top module: `pwm_offset_timer`

## Requirements
- R1: After reset, `count` is 0, `count_down` is 0, all outputs are low and `cap_valid` is low. The counter moves only while the run bit (config bit 15) is set. While that bit is clear, the counter is held at 0.
- R2: In edge mode (config bit 14 = 0), the counter advances by one each cycle. In the cycle after it equals the period, it returns to 0, so a period value P gives P+1 cycles. P = 0 holds the counter at 0.
- R3: In center mode (config bit 14 = 1), the counter runs 0,1,…,P,P−1,…,1 and repeats. `count_down` is high exactly on the descending values P−1 … 1, and P = 0 holds the counter at 0.
- R4: The outputs are registered. In the cycle after the counter held value c, `prim_out[i]` equals init[i] XOR (c ≥ cmp[i]), where init is config bits [2:0] and bit i belongs to channel i.
- R5: In the cycle after value c, `sec_out[i]` equals init[i] XOR (c ≥ cmp[i] + offset). The sum is formed 17 bits wide, so it never wraps. With an offset of 0, `sec_out` equals `prim_out`.
- R6: A compare value above the period holds that channel's outputs at the init level for the whole period.
- R7: A new period, offset, compare value, mode or init level takes effect only in the cycle the counter is set back to 0. Until then, the counter and the outputs follow the old values.
- R8: The run bit and the capture-enable bits (config bits [5:3], bit 3+i for channel i) act from the next clock edge.
- R9: A capture happens when `cap_in[i]` is first sampled high at edge k while its capture-enable bit is set. The value shown on `count` between edges k+1 and k+2 is then stored at edge k+2, and that channel becomes pending.
- R10: `cap_valid` is high while any channel is pending. `cap_chan` and `cap_data` show the lowest pending channel and its stored value. A handshake (valid and ready at an edge) clears that channel, unless a new capture for it lands at the same edge. A new capture overwrites a pending value.
- R11: The register map is: address 0 period, 1 offset, 2+i compare of channel i, 5 config. A write to an unmapped address (6 or 7) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| cap_in | input | 3 | Capture pins, one per channel, asynchronous |
| prim_out | output | 3 | Primary compare outputs |
| sec_out | output | 3 | Offset compare outputs |
| count | output | 16 | Current counter value |
| count_down | output | 1 | High while the counter is descending |
| cap_valid | output | 1 | Capture stream valid |
| cap_ready | input | 1 | Capture stream ready |
| cap_chan | output | 2 | Channel of the presented capture |
| cap_data | output | 16 | Counter value of the presented capture |

## Verification
The assertions assume that the capture pins may change at any time, since they are synchronized inside the block. They also assume that register writes are single-cycle strobes, which may arrive in any cycle, including the cycle in which the counter restarts. The bench keeps the period at 24 or below and the offset at 6 or below so that many periods run, and it draws compare values up to 30 so that values above the period come up often. It toggles capture pins and ready at random and sometimes clears the run bit, all while respecting these assumptions.

// File: rtl/pwm_offset_pkg.sv
package pwm_offset_pkg;
  typedef enum logic {
    MODE_EDGE   = 1'b0,
    MODE_CENTER = 1'b1
  } cnt_mode_e;

  localparam int ADDR_PERIOD   = 0;
  localparam int ADDR_OFFSET   = 1;
  localparam int ADDR_CMP_BASE = 2;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_offset_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  input  logic                    load,
  output logic [CW-1:0]           act_per,
  output logic [CW-1:0]           act_off,
  output logic [NCH-1:0][CW-1:0]  act_cmp,
  output logic [NCH-1:0]          act_init,
  output cnt_mode_e               act_mode,
  output logic                    run,
  output logic [NCH-1:0]          cap_en
);
  localparam int ADDR_CFG = ADDR_CMP_BASE + NCH;
  localparam int RUN_BIT  = CW - 1;
  localparam int MODE_BIT = CW - 2;

  logic [CW-1:0]          sh_per, sh_off;
  logic [NCH-1:0][CW-1:0] sh_cmp;
  logic [NCH-1:0]         sh_init;
  cnt_mode_e              sh_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per  <= '0;
      sh_off  <= '0;
      sh_cmp  <= '1;
      sh_init <= '0;
      sh_mode <= MODE_EDGE;
      run     <= 1'b0;
      cap_en  <= '0;
    end else if (we) begin
      if (addr == AW'(ADDR_PERIOD)) sh_per <= wdata;
      if (addr == AW'(ADDR_OFFSET)) sh_off <= wdata;
      for (int i = 0; i < NCH; i++) begin
        if (addr == AW'(ADDR_CMP_BASE + i)) sh_cmp[i] <= wdata;
      end
      if (addr == AW'(ADDR_CFG)) begin
        sh_init <= wdata[NCH-1:0];
        cap_en  <= wdata[2*NCH-1:NCH];
        sh_mode <= cnt_mode_e'(wdata[MODE_BIT]);
        run     <= wdata[RUN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per  <= '0;
      act_off  <= '0;
      act_cmp  <= '1;
      act_init <= '0;
      act_mode <= MODE_EDGE;
    end else if (load) begin
      act_per  <= sh_per;
      act_off  <= sh_off;
      act_cmp  <= sh_cmp;
      act_init <= sh_init;
      act_mode <= sh_mode;
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_offset_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  cnt_mode_e     mode,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt,
  output logic          dn,
  output logic          load
);
  logic [CW-1:0] cnt_nxt;
  logic          dn_nxt;

  always_comb begin
    cnt_nxt = cnt + CW'(1);
    dn_nxt  = 1'b0;
    if (!run) begin
      cnt_nxt = '0;
    end else if (mode == MODE_EDGE) begin
      if (cnt >= per) cnt_nxt = '0;
    end else begin
      if (dn) begin
        cnt_nxt = cnt - CW'(1);
        dn_nxt  = 1'b1;
      end else if (cnt >= per) begin
        cnt_nxt = (cnt == '0) ? '0 : cnt - CW'(1);
        dn_nxt  = 1'b1;
      end
      if (cnt_nxt == '0) dn_nxt = 1'b0;
    end
  end

  assign load = (cnt_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dn  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      dn  <= dn_nxt;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] off,
  input  logic          init,
  input  logic          cap_pin,
  input  logic          cap_en,
  output logic          prim,
  output logic          sec,
  output logic          cap_hit
);
  logic [CW:0] shifted;
  logic [2:0]  sync_q;

  assign shifted = {1'b0, cmp} + {1'b0, off};
  assign cap_hit = sync_q[1] & ~sync_q[2] & cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim   <= 1'b0;
      sec    <= 1'b0;
      sync_q <= '0;
    end else begin
      prim   <= init ^ (cnt >= cmp);
      sec    <= init ^ ({1'b0, cnt} >= shifted);
      sync_q <= {sync_q[1:0], cap_pin};
    end
  end
endmodule

// File: rtl/pwm_capture_queue.sv
module pwm_capture_queue #(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [CW-1:0]  cnt,
  input  logic           ready,
  output logic           valid,
  output logic [CHW-1:0] chan,
  output logic [CW-1:0]  data
);
  logic [NCH-1:0]         pend;
  logic [NCH-1:0][CW-1:0] store;
  logic                   take;

  always_comb begin
    chan = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) chan = CHW'(i);
    end
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chan == CHW'(i)) data = store[i];
    end
  end

  assign valid = |pend;
  assign take  = valid & ready;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend[g]  <= 1'b0;
          store[g] <= '0;
        end else begin
          if (hit[g]) store[g] <= cnt;
          pend[g] <= hit[g] | (pend[g] & ~(take && chan == CHW'(g)));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_offset_timer.sv
module pwm_offset_timer
  import pwm_offset_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_we,
  input  logic [AW-1:0]                    reg_addr,
  input  logic [CW-1:0]                    reg_wdata,
  input  logic [NCH-1:0]                   cap_in,
  output logic [NCH-1:0]                   prim_out,
  output logic [NCH-1:0]                   sec_out,
  output logic [CW-1:0]                    count,
  output logic                             count_down,
  output logic                             cap_valid,
  input  logic                             cap_ready,
  output logic [$clog2(NCH > 1 ? NCH : 2)-1:0] cap_chan,
  output logic [CW-1:0]                    cap_data
);
  localparam int CHW = $clog2(NCH > 1 ? NCH : 2);

  logic [CW-1:0]          act_per, act_off;
  logic [NCH-1:0][CW-1:0] act_cmp;
  logic [NCH-1:0]         act_init;
  cnt_mode_e              act_mode;
  logic                   run, load;
  logic [NCH-1:0]         cap_en, cap_hit;

  pwm_regfile #(.CW(CW), .NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .load(load), .act_per(act_per), .act_off(act_off), .act_cmp(act_cmp),
    .act_init(act_init), .act_mode(act_mode), .run(run), .cap_en(cap_en)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(act_mode), .per(act_per),
    .cnt(count), .dn(count_down), .load(load)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      pwm_channel #(.CW(CW)) u_ch (
        .clk(clk), .rst_n(rst_n), .cnt(count), .cmp(act_cmp[g]), .off(act_off),
        .init(act_init[g]), .cap_pin(cap_in[g]), .cap_en(cap_en[g]),
        .prim(prim_out[g]), .sec(sec_out[g]), .cap_hit(cap_hit[g])
      );
    end
  endgenerate

  pwm_capture_queue #(.CW(CW), .NCH(NCH), .CHW(CHW)) u_capq (
    .clk(clk), .rst_n(rst_n), .hit(cap_hit), .cnt(count), .ready(cap_ready),
    .valid(cap_valid), .chan(cap_chan), .data(cap_data)
  );
endmodule

// File: rtl/pwm_offset_timer_checker.sv
module pwm_offset_timer_checker #(
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run,
  input logic                   act_mode,
  input logic [CW-1:0]          act_per,
  input logic [CW-1:0]          act_off,
  input logic [NCH-1:0][CW-1:0] act_cmp,
  input logic [NCH-1:0]         act_init,
  input logic [CW-1:0]          count,
  input logic                   count_down,
  input logic [NCH-1:0]         prim_out,
  input logic [NCH-1:0]         sec_out,
  input logic                   cap_valid,
  input logic                   cap_ready
);
  a_r1_halt_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);

  a_r2_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    count <= act_per);

  a_r2_edge_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !act_mode && count == act_per) |=> count == '0);

  a_r3_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_mode && !count_down && act_per != '0 && count == act_per)
      |=> count == $past(act_per) - CW'(1));

  a_r5_zero_offset_same: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_off == '0) |-> sec_out == prim_out);

  a_r10_valid_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> cap_valid);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      a_r6_high_cmp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(act_cmp[g] > act_per) |-> (prim_out[g] == $past(act_init[g])));
    end
  endgenerate
endmodule

bind pwm_offset_timer pwm_offset_timer_checker #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .act_mode(act_mode), .act_per(act_per),
  .act_off(act_off), .act_cmp(act_cmp), .act_init(act_init), .count(count),
  .count_down(count_down), .prim_out(prim_out), .sec_out(sec_out),
  .cap_valid(cap_valid), .cap_ready(cap_ready)
);

// File: tb/pwm_offset_timer_test.sv
module pwm_offset_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [NCH-1:0] cap_in = '0;
  logic cap_ready = 1'b0;
  logic [NCH-1:0] prim_out, sec_out;
  logic [15:0] count, cap_data;
  logic count_down, cap_valid;
  logic [1:0] cap_chan;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string ptag = "";

  pwm_offset_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cap_in(cap_in), .prim_out(prim_out), .sec_out(sec_out),
    .count(count), .count_down(count_down), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_chan(cap_chan), .cap_data(cap_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state, built from the requirements
  logic [15:0] s_per, s_off, m_per, m_off, m_cnt;
  logic [NCH-1:0][15:0] s_cmp, m_cmp, m_cdat;
  logic [NCH-1:0] s_init, m_init, m_capen, m_pend, m_prim, m_sec;
  logic [NCH-1:0][2:0] m_sy;
  logic s_mode, m_mode, m_run, m_dn;

  task automatic model_reset();
    s_per = '0; s_off = '0; s_cmp = '1; s_init = '0; s_mode = 1'b0;
    m_per = '0; m_off = '0; m_cmp = '1; m_init = '0; m_mode = 1'b0;
    m_run = 1'b0; m_capen = '0; m_cnt = '0; m_dn = 1'b0;
    m_pend = '0; m_cdat = '0; m_sy = '0; m_prim = '0; m_sec = '0;
  endtask

  function automatic int low_pend(logic [NCH-1:0] p);
    for (int i = 0; i < NCH; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [NCH-1:0] hit;
    logic take;
    int oc;
    logic [15:0] nx;
    logic ndn;
    for (int i = 0; i < NCH; i++) begin
      m_prim[i] = m_init[i] ^ (m_cnt >= m_cmp[i]);
      m_sec[i]  = m_init[i] ^ ({1'b0, m_cnt} >= ({1'b0, m_cmp[i]} + {1'b0, m_off}));
      hit[i]    = m_sy[i][1] & ~m_sy[i][2] & m_capen[i];
    end
    oc = low_pend(m_pend);
    take = (|m_pend) & cap_ready;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) m_cdat[i] = m_cnt;
      m_pend[i] = hit[i] | (m_pend[i] & !(take && oc == i));
      m_sy[i] = {m_sy[i][1:0], cap_in[i]};
    end
    nx = m_cnt + 16'd1;
    ndn = 1'b0;
    if (!m_run) nx = '0;
    else if (!m_mode) begin
      if (m_cnt >= m_per) nx = '0;
    end else begin
      if (m_dn) begin nx = m_cnt - 16'd1; ndn = 1'b1; end
      else if (m_cnt >= m_per) begin nx = (m_cnt == 0) ? '0 : m_cnt - 16'd1; ndn = 1'b1; end
      if (nx == 0) ndn = 1'b0;
    end
    if (nx == 0) begin
      m_per = s_per; m_off = s_off; m_cmp = s_cmp; m_init = s_init; m_mode = s_mode;
    end
    m_cnt = nx;
    m_dn = ndn;
    if (reg_we) begin
      case (reg_addr)
        3'd0: s_per = reg_wdata;
        3'd1: s_off = reg_wdata;
        3'd2: s_cmp[0] = reg_wdata;
        3'd3: s_cmp[1] = reg_wdata;
        3'd4: s_cmp[2] = reg_wdata;
        3'd5: begin
          s_init = reg_wdata[2:0]; m_capen = reg_wdata[5:3];
          s_mode = reg_wdata[14]; m_run = reg_wdata[15];
        end
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    string ct;
    int oc;
    ct = (ptag != "") ? ptag : (m_mode ? "R3" : "R2");
    check(count == m_cnt, ct, "count", count, m_cnt);
    check(count_down == m_dn, ct, "count_down", count_down, m_dn);
    for (int i = 0; i < NCH; i++) begin
      check(prim_out[i] == m_prim[i], (m_cmp[i] > m_per) ? "R6" : "R4",
            $sformatf("prim_out[%0d]", i), prim_out[i], m_prim[i]);
      check(sec_out[i] == m_sec[i], "R5", $sformatf("sec_out[%0d]", i), sec_out[i], m_sec[i]);
    end
    check(cap_valid == (|m_pend), "R10", "cap_valid", cap_valid, |m_pend);
    if (|m_pend) begin
      oc = low_pend(m_pend);
      check(cap_chan == 2'(oc), "R10", "cap_chan", cap_chan, oc);
      check(cap_data == m_cdat[oc], "R9", "cap_data", cap_data, m_cdat[oc]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    step();
    reg_we = 1'b0;
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_v;
    logic [15:0] saved;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(count == 0, "R1", "reset count", count, 0);
    check(count_down == 0, "R1", "reset count_down", count_down, 0);
    check(prim_out == 0 && sec_out == 0, "R1", "reset outputs", {prim_out, sec_out}, 0);
    check(cap_valid == 0, "R1", "reset cap_valid", cap_valid, 0);

    // R1/R8: stopped counter stays at zero, then starts the cycle after run is set
    ptag = "R1";
    wr(0, 7); wr(2, 2); wr(3, 5); wr(4, 9); wr(1, 2);
    steps(3);
    ptag = "R8";
    wr(5, 16'h8002);
    check(count == 0, "R8", "count at run write", count, 0);
    step();
    check(count == 1, "R8", "count after run", count, 1);
    ptag = "R2";
    steps(30);

    // R7: new period written mid-period waits for the restart
    ptag = "R7";
    while (count != 2) step();
    wr(0, 3);
    saved = count;
    steps(4);
    check(count == saved + 4, "R7", "old period kept", count, saved + 4);
    steps(20);

    // R3: center mode with various periods, then R6 with a compare above the period
    ptag = "R3";
    wr(5, 16'hC005); wr(0, 5); steps(30);
    wr(0, 1); steps(12);
    wr(0, 0); steps(8);
    ptag = "R6";
    wr(0, 10); wr(5, 16'h8000); wr(2, 20); wr(3, 11); wr(1, 0); steps(30);
    ptag = "R5";
    wr(1, 3); wr(2, 4); steps(30);

    // R11: unmapped addresses have no effect
    ptag = "R11";
    wr(6, 16'h0000); wr(7, 16'hFFFF); wr(6, 16'h4001); steps(25);

    // R9: capture timing, checked directly against count
    ptag = "";
    wr(0, 60); wr(5, 16'h8038);
    cap_ready = 1'b1;
    steps(5);
    cap_in[1] = 1'b1;
    step(); step();
    exp_v = count;
    step();
    check(cap_valid && cap_chan == 2'd1, "R9", "capture presented", cap_chan, 1);
    check(cap_data == 16'(exp_v), "R9", "captured value", cap_data, exp_v);
    step();
    check(!cap_valid, "R10", "drained after handshake", cap_valid, 0);
    cap_in = '0; steps(4);

    // R10: back-pressure, overwrite and preemption
    cap_ready = 1'b0;
    cap_in[2] = 1'b1; steps(5);
    cap_in[2] = 1'b0; steps(4);
    cap_in[2] = 1'b1; steps(4);
    cap_in[0] = 1'b1; steps(4);
    check(cap_valid && cap_chan == 2'd0, "R10", "lower channel first", cap_chan, 0);
    cap_ready = 1'b1; step();
    check(cap_valid && cap_chan == 2'd2, "R10", "next pending channel", cap_chan, 2);
    steps(3);
    cap_in = '0; steps(4);

    // random phase
    for (int n = 0; n < 16000; n++) begin
      int r, a, d;
      cap_ready = ($urandom % 4) != 0;
      if (($urandom % 6) == 0) cap_in[$urandom % NCH] ^= 1'b1;
      r = $urandom % 100;
      if (r < 4) begin
        a = $urandom % 8;
        case (a)
          0: d = $urandom % 25;
          1: d = $urandom % 7;
          2, 3, 4: d = $urandom % 31;
          5: begin
            d = $urandom & 16'h003F;
            if ($urandom % 2) d |= 16'h4000;
            if (($urandom % 8) != 0) d |= 16'h8000;
          end
          default: d = $urandom & 16'hFFFF;
        endcase
        wr(a, d);
      end else begin
        step();
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule